// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block steps a microprogrammed control unit through its control store. It holds a 7-bit control address register and a single return-address register. It also holds a 128-word by 20-bit control store, and it presents the microoperation bits of the current microinstruction to a datapath. On every rising clock edge it computes the next control address from the current word and the datapath status. The address can increment, take a conditional jump, take a conditional call that saves a return address, return through the saved address, or map a 4-bit opcode to the start of that opcode's routine.

The control store is filled through a simple preload port while the sequencer is held in reset. After reset is released, the block fetches one microinstruction per cycle. The datapath supplies three status flags and the opcode bits. It receives in return the nine microoperation bits, together with the address they were fetched from.

A microinstruction is laid out as follows, from bit 19 down to bit 0:

| Bits | Content |
|---|---|
| 19..11 | Microoperation bits |
| 10..9 | Condition select |
| 8..7 | Branch type |
| 6..0 | Target address |

Top module: `uaddr_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the control address becomes `START_ADDR` (default 64) and the return register is cleared to 0. A return taken before any call therefore goes to address 0.
- R2: `uop_o` always equals bits 19..11 of the store word at the address shown on `car_o`, in the same cycle.
- R3: The condition select (bits 10..9) picks the condition as follows: 00 is always true, 01 is `indir_i`, 10 is `acsign_i`, and 11 is `aczero_i`.
- R4: Branch type 00 (jump): the control address loads the target (bits 6..0) when the condition is true. Otherwise it increments, and 127 wraps to 0.
- R5: Branch type 01 (call) with a true condition: the control address loads the target, and the return register receives the current address plus one.
- R6: Branch type 01 with a false condition: the control address increments, and the return register keeps its value.
- R7: Branch type 10 (return): the control address loads the return register, whatever the condition.
- R8: Branch type 11 (map): the control address becomes {0, `opcode_i`[3:0], 00}. For example, opcode 1011 gives address 44.
- R9: The return register holds one level only. A call made inside a called routine replaces the earlier return address, so both returns go to the most recent return address.
- R10: A preload write changes the store only when `pl_we` is high while `rst` is high. A write made while `rst` is low leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 7 | Preload word address |
| pl_data | input | 20 | Preload word |
| indir_i | input | 1 | Indirect flag from the datapath |
| acsign_i | input | 1 | Accumulator sign flag |
| aczero_i | input | 1 | Accumulator-is-zero flag |
| opcode_i | input | 4 | Opcode bits used by the map branch |
| uop_o | output | 9 | Microoperation bits of the current word |
| car_o | output | 7 | Current control address |

## Verification
On every cycle the assertions check the following:
- the address that follows each branch type, for jump taken and not taken, return and map;
- the saving of the return address on a taken call;
- that the return register holds its value when no call is taken;
- the start address after reset.

Some behaviours show up only over several steps, so only the bench scenarios can show them:
- how the condition select routes each status flag;
- the loss of the outer return address after a nested call;
- the clearing of the return register by reset;
- the address wrap from 127 to 0;
- the fact that a preload write outside reset has no effect.

// File: rtl/uaddr_pkg.sv
package uaddr_pkg;
  localparam int ADDR_W = 7;
  localparam int WORD_W = 20;
  localparam int UOP_W  = 9;
  localparam int OPC_W  = 4;
  localparam int SEL_W  = 2;

  localparam int TGT_LSB = 0;
  localparam int BR_LSB  = ADDR_W;
  localparam int SEL_LSB = ADDR_W + 2;
  localparam int UOP_LSB = ADDR_W + 2 + SEL_W;

  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    SEL_ALWAYS = 2'b00,
    SEL_INDIR  = 2'b01,
    SEL_SIGN   = 2'b10,
    SEL_ZERO   = 2'b11
  } cond_sel_e;

  typedef struct packed {
    logic [UOP_W-1:0]  uop;
    cond_sel_e         sel;
    br_kind_e          br;
    logic [ADDR_W-1:0] tgt;
  } uword_t;
endpackage

// File: rtl/uaddr_store.sv
module uaddr_store #(
  parameter int AW = 7,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Write port and registered read port, in a form that maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/uaddr_cond.sv
module uaddr_cond #(
  parameter int SW = 2
) (
  input  logic [SW-1:0] sel,
  input  logic          indir,
  input  logic          sign,
  input  logic          zero,
  output logic          cond
);
  localparam int NSRC = 1 << SW;

  logic [NSRC-1:0] src;

  // Index 0 is the constant-true source; the three flags follow in select order.
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      if (g == 0)      begin : g_one assign src[g] = 1'b1;  end
      else if (g == 1) begin : g_ind assign src[g] = indir; end
      else if (g == 2) begin : g_sgn assign src[g] = sign;  end
      else if (g == 3) begin : g_zer assign src[g] = zero;  end
      else             begin : g_pad assign src[g] = 1'b0;  end
    end
  endgenerate

  assign cond = src[sel];
endmodule

// File: rtl/uaddr_next.sv
module uaddr_next
  import uaddr_pkg::*;
#(
  parameter int AW  = 7,
  parameter int OPW = 4
) (
  input  logic [AW-1:0]  car,
  input  logic [AW-1:0]  sbr,
  input  br_kind_e       br,
  input  logic [AW-1:0]  tgt,
  input  logic           cond,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  nxt,
  output logic           sbr_we,
  output logic [AW-1:0]  sbr_d
);
  localparam int MAP_LO = 2;
  localparam int MAP_HI = AW - OPW - MAP_LO;

  logic [AW-1:0] incr;
  logic [AW-1:0] mapped;

  // The increment wraps at the top of the address space.
  assign incr   = car + AW'(1);
  assign mapped = {{MAP_HI{1'b0}}, opcode, {MAP_LO{1'b0}}};
  assign sbr_d  = incr;

  always_comb begin
    nxt    = incr;
    sbr_we = 1'b0;
    unique case (br)
      BR_JUMP: nxt = cond ? tgt : incr;
      BR_CALL: begin
        nxt    = cond ? tgt : incr;
        sbr_we = cond;
      end
      BR_RET:  nxt = sbr;
      BR_MAP:  nxt = mapped;
      default: nxt = incr;
    endcase
  end
endmodule

// File: rtl/uaddr_sequencer.sv
module uaddr_sequencer
  import uaddr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = 7'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [WORD_W-1:0] pl_data,
  input  logic              indir_i,
  input  logic              acsign_i,
  input  logic              aczero_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output logic [UOP_W-1:0]  uop_o,
  output logic [ADDR_W-1:0] car_o
);
  logic [ADDR_W-1:0] car_q;
  logic [ADDR_W-1:0] sbr_q;
  logic [WORD_W-1:0] cdr_raw;
  uword_t            cdr_q;
  logic [ADDR_W-1:0] nxt_w;
  logic [ADDR_W-1:0] rd_addr;
  logic              cond_w;
  logic              sbr_we;
  logic [ADDR_W-1:0] sbr_d;
  logic              st_we;

  // Writes reach the store only while reset holds the sequencer.
  assign st_we = pl_we & rst;

  // The store is read at the address the register is about to take,
  // so the data register always holds the word at car_q.
  assign rd_addr = rst ? START_ADDR : nxt_w;

  uaddr_store #(.AW(ADDR_W), .DW(WORD_W)) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (pl_addr),
    .wdata (pl_data),
    .raddr (rd_addr),
    .rdata (cdr_raw)
  );

  assign cdr_q = uword_t'(cdr_raw);

  uaddr_cond #(.SW(SEL_W)) u_cond (
    .sel   (cdr_q.sel),
    .indir (indir_i),
    .sign  (acsign_i),
    .zero  (aczero_i),
    .cond  (cond_w)
  );

  uaddr_next #(.AW(ADDR_W), .OPW(OPC_W)) u_next (
    .car    (car_q),
    .sbr    (sbr_q),
    .br     (cdr_q.br),
    .tgt    (cdr_q.tgt),
    .cond   (cond_w),
    .opcode (opcode_i),
    .nxt    (nxt_w),
    .sbr_we (sbr_we),
    .sbr_d  (sbr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= START_ADDR;
      sbr_q <= '0;
    end else begin
      car_q <= nxt_w;
      if (sbr_we) sbr_q <= sbr_d;
    end
  end

  assign car_o = car_q;
  assign uop_o = cdr_q.uop;
endmodule

// File: rtl/uaddr_sequencer_chk.sv
module uaddr_sequencer_chk
  import uaddr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = 7'd64
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr,
  input uword_t            word,
  input logic              cond,
  input logic [OPC_W-1:0]  opcode
);
  AST_RESET_START: assert property (@(posedge clk)
    rst |=> car == START_ADDR); // R1

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (word.br == BR_JUMP && cond) |=> car == $past(word.tgt)); // R4

  AST_JUMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (word.br == BR_JUMP && !cond) |=> car == ADDR_W'($past(car) + ADDR_W'(1))); // R4

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (rst)
    (word.br == BR_CALL && cond) |=> sbr == ADDR_W'($past(car) + ADDR_W'(1))); // R5

  AST_CALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(word.br == BR_CALL && cond) |=> $stable(sbr)); // R6

  AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
    (word.br == BR_RET) |=> car == $past(sbr)); // R7

  AST_MAP_FORM: assert property (@(posedge clk) disable iff (rst)
    (word.br == BR_MAP) |=> car == {1'b0, $past(opcode), 2'b00}); // R8
endmodule

bind uaddr_sequencer uaddr_sequencer_chk #(.START_ADDR(START_ADDR)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .car    (car_q),
  .sbr    (sbr_q),
  .word   (cdr_q),
  .cond   (cond_w),
  .opcode (opcode_i)
);

// File: tb/uaddr_sequencer_bench.sv
module uaddr_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pl_we = 1'b0;
  logic [6:0]  pl_addr = '0;
  logic [19:0] pl_data = '0;
  logic        indir_i = 1'b0;
  logic        acsign_i = 1'b0;
  logic        aczero_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic [8:0]  uop_o;
  logic [6:0]  car_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  uaddr_sequencer u_uaddr_sequencer (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .indir_i(indir_i), .acsign_i(acsign_i), .aczero_i(aczero_i),
    .opcode_i(opcode_i), .uop_o(uop_o), .car_o(car_o)
  );

  // Word fields: uop 19..11, select 10..9, branch 8..7, target 6..0.
  function automatic logic [19:0] mk(logic [6:0] a, logic [1:0] sel, logic [1:0] br, logic [6:0] tgt);
    return {2'b10, a, sel, br, tgt};
  endfunction

  function automatic logic [8:0] uop_of(logic [6:0] a);
    return {2'b10, a};
  endfunction

  task automatic chk(string req, logic [6:0] exp_car);
    checks++;
    if (car_o !== exp_car) begin
      fails++;
      $display("FAIL %s car actual=%0d expected=%0d", req, car_o, exp_car);
    end
    checks++;
    if (uop_o !== uop_of(exp_car)) begin
      fails++;
      $display("FAIL %s R2 uop actual=%h expected=%h", req, uop_o, uop_of(exp_car));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(logic z, logic s, logic ind, logic [3:0] op);
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    aczero_i = z; acsign_i = s; indir_i = ind; opcode_i = op;
    rst = 1'b0;
  endtask

  task automatic put(logic [6:0] a, logic [19:0] w);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = w;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic load_program();
    for (int a = 0; a < 128; a++) put(7'(a), mk(7'(a), 2'b00, 2'b00, 7'd0));
    put(7'd64,  mk(7'd64,  2'b00, 2'b00, 7'd66));
    put(7'd66,  mk(7'd66,  2'b11, 2'b00, 7'd70));
    put(7'd67,  mk(7'd67,  2'b10, 2'b00, 7'd72));
    put(7'd68,  mk(7'd68,  2'b01, 2'b00, 7'd74));
    put(7'd69,  mk(7'd69,  2'b00, 2'b00, 7'd127));
    put(7'd127, mk(7'd127, 2'b11, 2'b00, 7'd5));
    put(7'd70,  mk(7'd70,  2'b00, 2'b01, 7'd80));
    put(7'd80,  mk(7'd80,  2'b11, 2'b10, 7'd0));
    put(7'd71,  mk(7'd71,  2'b11, 2'b01, 7'd90));
    put(7'd72,  mk(7'd72,  2'b00, 2'b10, 7'd0));
    put(7'd74,  mk(7'd74,  2'b00, 2'b11, 7'd0));
    put(7'd90,  mk(7'd90,  2'b00, 2'b01, 7'd100));
    put(7'd100, mk(7'd100, 2'b00, 2'b10, 7'd0));
    put(7'd91,  mk(7'd91,  2'b00, 2'b10, 7'd0));
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b1, 1'b0, 4'd0);
    chk("R1 start", 7'd64);
    step(); chk("R4 unconditional jump", 7'd66);
    step(); chk("R3 zero flag low", 7'd67);
    step(); chk("R3 sign flag high", 7'd72);
    step(); chk("R1 cleared return register", 7'd0);
  endtask

  task automatic t_wrap();
    do_reset(1'b0, 1'b0, 1'b0, 4'd0);
    step(); step(); step(); chk("R3 indirect low", 7'd68);
    step(); chk("R4 not taken increments", 7'd69);
    step(); chk("R4 jump", 7'd127);
    step(); chk("R4 wrap 127 to 0", 7'd0);
  endtask

  task automatic t_map();
    do_reset(1'b0, 1'b0, 1'b1, 4'b1011);
    step(); step(); step(); step(); chk("R3 indirect high", 7'd74);
    step(); chk("R8 map opcode 1011", 7'd44);
    do_reset(1'b0, 1'b0, 1'b1, 4'b1111);
    step(); step(); step(); step(); step(); chk("R8 map opcode 1111", 7'd60);
  endtask

  task automatic t_calls();
    do_reset(1'b1, 1'b0, 1'b0, 4'd0);
    step(); step(); chk("R3 zero flag high", 7'd70);
    step(); chk("R5 call taken", 7'd80);
    step(); chk("R7 return", 7'd71);
    aczero_i = 1'b0;
    step(); chk("R6 call not taken increments", 7'd72);
    step(); chk("R6 return register kept", 7'd71);
    aczero_i = 1'b1;
    step(); chk("R5 conditional call taken", 7'd90);
    step(); chk("R9 nested call", 7'd100);
    step(); chk("R9 inner return", 7'd91);
    step(); chk("R9 outer return address lost", 7'd91);
  endtask

  task automatic t_preload_ignored();
    do_reset(1'b0, 1'b0, 1'b0, 4'd0);
    put(7'd64, 20'h00000);
    do_reset(1'b0, 1'b0, 1'b0, 4'd0);
    chk("R10 write outside reset ignored", 7'd64);
    step(); chk("R10 start word intact", 7'd66);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R0 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    load_program();
    t_reset_state();
    t_wrap();
    t_map();
    t_calls();
    t_preload_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule